// File: doc/BRIEF.md
# Video chroma-format pixel packer

This block sits in a two-pixel-per-clock video stream with three 10-bit components per pixel. It repacks every beat into the 64-bit bus layout that a runtime colour-format select asks for: RGB, YUV 4:4:4, YUV 4:2:2 or YUV 4:2:0. Lanes that the chosen format does not use are driven to zero.

The input carries pixel 0 in bits 29:0 and pixel 1 in bits 59:30. Each pixel holds component A (G or Y) in its low 10 bits, component B (B or U) in the middle 10 bits and component C (R or V) in its top 10 bits. Start of frame (TUSER) and end of line (TLAST) travel with their beat.

The block follows line parity inside each frame, so that even and odd lines of 4:2:0 get different layouts. A single registered output stage handles downstream backpressure without losing or repeating any beat.

Top module: `vpk_packer`

## Requirements
- R1: The output data bus is 64 bits wide. Bits 63:60 are zero on every valid output beat.
- R2: Format code 0 (RGB) places each pixel as A in bits 9:0, B in bits 19:10 and C in bits 29:20 of its 30-bit slot. Pixel 0 occupies bits 29:0 and pixel 1 occupies bits 59:30.
- R3: Format code 1 (YUV 4:4:4) uses the same slot layout as R2, with Y as A, U as B and V as C.
- R4: Format code 2 (YUV 4:2:2) carries, in 10-bit lanes from bit 0 upward, pixel 0 Y, pixel 0 U, pixel 1 Y and pixel 0 V. Bits 63:40 are zero and the chroma of pixel 1 is discarded.
- R5: Format code 3 (YUV 4:2:0) on an even line produces the same layout as R4.
- R6: Format code 3 on an odd line carries pixel 0 Y in bits 9:0 and pixel 1 Y in bits 29:20. All other bits are zero.
- R7: TUSER and TLAST leave the block on the same beat as the data they arrived with.
- R8: A beat with TUSER set is on line 0, which is even. After every accepted beat with TLAST set, the line number advances by one.
- R9: The format select is captured only on an accepted beat with TUSER set, and that beat already uses the new format. Before the first start of frame after reset, the format is RGB.
- R10: The output holds data, TUSER and TLAST steady while it is valid and not ready. The input is ready whenever the output is empty or is being taken in the same cycle. No beat is lost or duplicated.
- R11: After reset the output is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel_i | input | 2 | Colour format code, sampled at start of frame |
| s_tdata_i | input | 60 | Input pixel pair |
| s_tvalid_i | input | 1 | Input valid |
| s_tready_o | output | 1 | Input ready |
| s_tuser_i | input | 1 | Input start of frame |
| s_tlast_i | input | 1 | Input end of line |
| m_tdata_o | output | 64 | Packed output beat |
| m_tvalid_o | output | 1 | Output valid |
| m_tready_i | input | 1 | Output ready |
| m_tuser_o | output | 1 | Output start of frame |
| m_tlast_o | output | 1 | Output end of line |

## Verification
The hardest situation to reach from the ports is a change of format in the middle of a frame, combined with a stalled output beat on an odd 4:2:0 line. Here the packed beat must keep the layout latched at start of frame, and the line parity must stay correct across the stall.

The stimulus picks a new random format on every beat, not only at frame starts, and builds frames of random line counts and lengths. It toggles downstream ready at random. The stream also begins with a beat that is not a start of frame, which exercises the reset default of the format.

// File: rtl/vpk_pkg.sv
package vpk_pkg;
    parameter int unsigned COMP_W  = 10;
    parameter int unsigned N_COMP  = 3;
    parameter int unsigned N_PIX   = 2;
    localparam int unsigned PIX_W  = COMP_W * N_COMP;
    localparam int unsigned IN_W   = PIX_W * N_PIX;
    localparam int unsigned BUS_W  = ((IN_W + 7) / 8) * 8;

    typedef enum logic [1:0] {
        FMT_RGB    = 2'd0,
        FMT_YUV444 = 2'd1,
        FMT_YUV422 = 2'd2,
        FMT_YUV420 = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [COMP_W-1:0] c;
        logic [COMP_W-1:0] b;
        logic [COMP_W-1:0] a;
    } pixel_t;

    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic             sof;
        logic             eol;
    } beat_t;

    function automatic pixel_t get_pix(input logic [IN_W-1:0] d, input int unsigned idx);
        return pixel_t'(d[idx*PIX_W +: PIX_W]);
    endfunction
endpackage

// File: rtl/vpk_line_tracker.sv
module vpk_line_tracker
    import vpk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept_i,
    input  logic       sof_i,
    input  logic       eol_i,
    input  logic [1:0] fmt_sel_i,
    output fmt_e       beat_fmt_o,
    output logic       beat_odd_o
);
    fmt_e fmt_q;
    logic odd_q;

    always_comb begin
        beat_fmt_o = sof_i ? fmt_e'(fmt_sel_i) : fmt_q;
        beat_odd_o = sof_i ? 1'b0 : odd_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q <= FMT_RGB;
            odd_q <= 1'b0;
        end else if (accept_i) begin
            fmt_q <= beat_fmt_o;
            odd_q <= beat_odd_o ^ eol_i;
        end
    end
endmodule

// File: rtl/vpk_lane_mapper.sv
module vpk_lane_mapper
    import vpk_pkg::*;
(
    input  logic [IN_W-1:0]  pix_i,
    input  fmt_e             fmt_i,
    input  logic             odd_i,
    output logic [BUS_W-1:0] bus_o
);
    logic [BUS_W-1:0] full_w;
    logic [BUS_W-1:0] sub_w;
    logic [BUS_W-1:0] luma_w;
    pixel_t p0, p1;

    assign p0 = get_pix(pix_i, 0);
    assign p1 = get_pix(pix_i, 1);

    genvar gi;
    generate
        for (gi = 0; gi < N_PIX; gi++) begin : g_slot
            assign full_w[gi*PIX_W +: PIX_W] = pix_i[gi*PIX_W +: PIX_W];
        end
        if (BUS_W > IN_W) begin : g_pad
            assign full_w[BUS_W-1:IN_W] = '0;
        end
    endgenerate

    always_comb begin
        sub_w = '0;
        sub_w[0*COMP_W +: COMP_W] = p0.a;
        sub_w[1*COMP_W +: COMP_W] = p0.b;
        sub_w[2*COMP_W +: COMP_W] = p1.a;
        sub_w[3*COMP_W +: COMP_W] = p0.c;
        luma_w = '0;
        luma_w[0*COMP_W +: COMP_W] = p0.a;
        luma_w[2*COMP_W +: COMP_W] = p1.a;
    end

    always_comb begin
        unique case (fmt_i)
            FMT_RGB, FMT_YUV444: bus_o = full_w;
            FMT_YUV422:          bus_o = sub_w;
            FMT_YUV420:          bus_o = odd_i ? luma_w : sub_w;
            default:             bus_o = '0;
        endcase
    end
endmodule

// File: rtl/vpk_out_reg.sv
module vpk_out_reg
    import vpk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t beat_i,
    input  logic  valid_i,
    output logic  ready_o,
    output beat_t beat_o,
    output logic  valid_o,
    input  logic  ready_i
);
    beat_t beat_q;
    logic  valid_q;

    assign ready_o = !valid_q || ready_i;
    assign beat_o  = beat_q;
    assign valid_o = valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            beat_q  <= '0;
        end else if (valid_i && ready_o) begin
            valid_q <= 1'b1;
            beat_q  <= beat_i;
        end else if (ready_i) begin
            valid_q <= 1'b0;
        end
    end
endmodule

// File: rtl/vpk_packer.sv
module vpk_packer
    import vpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        fmt_sel_i,
    input  logic [IN_W-1:0]   s_tdata_i,
    input  logic              s_tvalid_i,
    output logic              s_tready_o,
    input  logic              s_tuser_i,
    input  logic              s_tlast_i,
    output logic [BUS_W-1:0]  m_tdata_o,
    output logic              m_tvalid_o,
    input  logic              m_tready_i,
    output logic              m_tuser_o,
    output logic              m_tlast_o
);
    fmt_e  beat_fmt;
    logic  beat_odd;
    logic  accept;
    beat_t in_beat, out_beat;
    logic [BUS_W-1:0] mapped;

    assign accept = s_tvalid_i && s_tready_o;

    vpk_line_tracker u_track (
        .clk        (clk),
        .rst        (rst),
        .accept_i   (accept),
        .sof_i      (s_tuser_i),
        .eol_i      (s_tlast_i),
        .fmt_sel_i  (fmt_sel_i),
        .beat_fmt_o (beat_fmt),
        .beat_odd_o (beat_odd)
    );

    vpk_lane_mapper u_map (
        .pix_i (s_tdata_i),
        .fmt_i (beat_fmt),
        .odd_i (beat_odd),
        .bus_o (mapped)
    );

    assign in_beat = '{data: mapped, sof: s_tuser_i, eol: s_tlast_i};

    vpk_out_reg u_out (
        .clk     (clk),
        .rst     (rst),
        .beat_i  (in_beat),
        .valid_i (s_tvalid_i),
        .ready_o (s_tready_o),
        .beat_o  (out_beat),
        .valid_o (m_tvalid_o),
        .ready_i (m_tready_i)
    );

    assign m_tdata_o = out_beat.data;
    assign m_tuser_o = out_beat.sof;
    assign m_tlast_o = out_beat.eol;
endmodule

// File: rtl/vpk_packer_chk.sv
module vpk_packer_chk
    import vpk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        fmt_sel_i,
    input logic [IN_W-1:0]   s_tdata_i,
    input logic              s_tvalid_i,
    input logic              s_tready_o,
    input logic              s_tuser_i,
    input logic              s_tlast_i,
    input logic [BUS_W-1:0]  m_tdata_o,
    input logic              m_tvalid_o,
    input logic              m_tready_i,
    input logic              m_tuser_o,
    input logic              m_tlast_o
);
    p_pad_zero_r1: assert property (@(posedge clk) disable iff (rst)
        m_tvalid_o |-> (m_tdata_o[BUS_W-1:IN_W] == '0));

    p_hold_data_r10: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid_o && !m_tready_i) |=> (m_tvalid_o && $stable(m_tdata_o)));

    p_hold_flags_r7: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid_o && !m_tready_i) |=> ($stable(m_tuser_o) && $stable(m_tlast_o)));

    p_empty_ready_r10: assert property (@(posedge clk) disable iff (rst)
        !m_tvalid_o |-> s_tready_o);

    p_accept_fill_r10: assert property (@(posedge clk) disable iff (rst)
        (s_tvalid_i && s_tready_o) |=> m_tvalid_o);
endmodule

bind vpk_packer vpk_packer_chk u_chk (.*);

// File: tb/vpk_packer_tb.sv
module vpk_packer_tb_top;
    localparam int INW = 60;
    localparam int BW  = 64;

    logic clk = 1'b0;
    logic rst;
    logic [1:0] fmt_sel;
    logic [INW-1:0] s_tdata;
    logic s_tvalid, s_tready, s_tuser, s_tlast;
    logic [BW-1:0] m_tdata;
    logic m_tvalid, m_tready, m_tuser, m_tlast;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2ns clk = ~clk;

    vpk_packer dut_i (
        .clk(clk), .rst(rst), .fmt_sel_i(fmt_sel),
        .s_tdata_i(s_tdata), .s_tvalid_i(s_tvalid), .s_tready_o(s_tready),
        .s_tuser_i(s_tuser), .s_tlast_i(s_tlast),
        .m_tdata_o(m_tdata), .m_tvalid_o(m_tvalid), .m_tready_i(m_tready),
        .m_tuser_o(m_tuser), .m_tlast_o(m_tlast)
    );

    function automatic logic [BW-1:0] pack_exp(input logic [INW-1:0] d, input int f, input bit odd);
        logic [BW-1:0] r;
        logic [9:0] y0, u0, v0, y1;
        y0 = d[9:0]; u0 = d[19:10]; v0 = d[29:20]; y1 = d[39:30];
        r = '0;
        if (f < 2) r[59:0] = d;
        else if (f == 3 && odd) begin
            r[9:0] = y0; r[29:20] = y1;
        end else begin
            r[9:0] = y0; r[19:10] = u0; r[29:20] = y1; r[39:30] = v0;
        end
        return r;
    endfunction

    function automatic string tag_of(input int f, input bit odd);
        if (f == 0) return "R2";
        if (f == 1) return "R3";
        if (f == 2) return "R4";
        return odd ? "R6" : "R5";
    endfunction

    task automatic check(input bit ok, input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [BW-1:0] q_data [$];
    logic          q_sof  [$];
    logic          q_eol  [$];
    string         q_tag  [$];

    initial begin
        int mdl_fmt;
        bit mdl_odd;
        int beats_left, lines_left;
        bit held;
        bit sof_next;
        int total_out;
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; s_tvalid = 0; s_tuser = 0; s_tlast = 0; s_tdata = '0;
        fmt_sel = 2'd3; m_tready = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(m_tvalid == 1'b0, "R11", {63'd0, m_tvalid}, '0);
        mdl_fmt = 0; mdl_odd = 0; held = 0; total_out = 0;
        // first beat is not a start of frame: reset default format applies (R9)
        sof_next = 0; beats_left = 2; lines_left = 1;
        for (int cyc = 0; cyc < 20000; cyc++) begin
            @(negedge clk);
            if (!held) begin
                s_tvalid = ($urandom_range(0, 3) != 0);
                if (s_tvalid) begin
                    s_tdata = {$urandom(), $urandom()} & {INW{1'b1}};
                    s_tuser = sof_next;
                    s_tlast = (beats_left == 1);
                end
            end
            fmt_sel  = 2'($urandom_range(0, 3));
            m_tready = (cyc < 40) ? (cyc % 5 == 0) : ($urandom_range(0, 2) != 0);
            #1;
            if (m_tvalid && !m_tready)
                check(s_tready == 1'b0, "R10", {63'd0, s_tready}, '0);
            if (!m_tvalid)
                check(s_tready == 1'b1, "R10", {63'd0, s_tready}, 64'd1);
            if (m_tvalid && m_tready) begin
                if (q_data.size() == 0) begin
                    check(1'b0, "R10", m_tdata, '0);
                end else begin
                    logic [BW-1:0] ed; logic es, ee; string t;
                    ed = q_data.pop_front(); es = q_sof.pop_front();
                    ee = q_eol.pop_front(); t = q_tag.pop_front();
                    check(m_tdata == ed, t, m_tdata, ed);
                    check(m_tdata[63:60] == 4'd0, "R1", m_tdata, ed);
                    check({m_tuser, m_tlast} == {es, ee}, "R7",
                          {62'd0, m_tuser, m_tlast}, {62'd0, es, ee});
                    total_out++;
                end
            end
            if (s_tvalid && s_tready) begin
                int bf; bit bo;
                bf = s_tuser ? int'(fmt_sel) : mdl_fmt;
                bo = s_tuser ? 1'b0 : mdl_odd;
                q_data.push_back(pack_exp(s_tdata, bf, bo));
                q_sof.push_back(s_tuser);
                q_eol.push_back(s_tlast);
                q_tag.push_back(tag_of(bf, bo));
                mdl_fmt = bf;
                mdl_odd = bo ^ s_tlast;
                held = 0;
                sof_next = 0;
                beats_left--;
                if (beats_left == 0) begin
                    lines_left--;
                    beats_left = $urandom_range(1, 4);
                    if (lines_left == 0) begin
                        lines_left = $urandom_range(2, 5);
                        sof_next = 1;
                    end
                end
            end else begin
                held = s_tvalid;
            end
        end
        check(total_out > 1000, "R8", 64'(total_out), 64'd1000);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #500us;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule